// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and everything that CPU can reach. It maps each CPU access either onto one flat, 17-bit physical address into a shared synchronous memory that holds work RAM, program ROM and configuration RAM, or onto a chip select for one of the memory-mapped peripherals: an input port unit, a sound port unit, a blitter register file, a colour palette store and a video line readback.

The lowest part of the CPU space is banked. A one-bit latch, loaded by a write to a control address, chooses whether reads there see RAM or ROM. Writes to the banked region always reach RAM, whatever the latch holds. Software can therefore read sprite data from ROM while writing the framebuffer RAM behind the same addresses. Read data returns to the CPU one cycle after the access, from whichever source the access selected. Unmapped I/O reads return all ones.

Top module: `bank_addr_decode`

## Requirements
- R1: After reset the bank latch selects RAM (a banked read at 0x1234 drives memAddr 0x01234), and cpuRdData reads 0xFF.
- R2: With the latch clear, a read at 0x0000–0x8FFF drives memEn=1, memWe=0 and memAddr equal to the CPU address, with bit 16 clear.
- R3: A write to 0xC900 loads the latch from bit 0 of the write data (1 = ROM). From the next cycle on, banked reads drive memAddr = 0x10000 + CPU address. Writing a 0 in bit 0 restores RAM reads.
- R4: A write at 0x0000–0x8FFF drives memWe=1 with memAddr equal to the CPU address (bit 16 clear), whatever the latch holds.
- R5: Accesses at 0x9000–0xBFFF always map to physical RAM at the same address, both reads and writes, whatever the latch holds.
- R6: Reads at 0xD000–0xFFFF map to 0x1D000–0x1FFFF. Writes there drive neither memEn nor memWe.
- R7: Accesses at 0xCC00–0xCFFF map to physical 0x0CC00–0x0CFFF and may read and write.
- R8: 0xC804–0xC807 asserts inPortSel and 0xC80C–0xC80F asserts sndPortSel, only while cpuValid is high. At most one select is high at a time. periphAddr carries CPU address bits 3:0, and periphWe follows cpuValid and cpuWe.
- R9: 0xCA00–0xCA07 asserts blitSel and 0xC000–0xC00F asserts palSel. The addresses just outside these ranges (0xCA08, 0xC010) assert neither.
- R10: A read at 0xCB00 asserts vidSel. One cycle later it returns the videoLine value sampled in the cycle of the access.
- R11: Read data appears on cpuRdData in the cycle after the read. It comes from memRdData for memory regions and from the matching peripheral data input for peripheral regions, and it holds until the next read.
- R12: A read of an unmapped I/O address in 0xC000–0xCBFF (including 0xC900) returns 0xFF, drives no select and no memory access. A write to 0xC900 makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU access in this cycle |
| cpuWe | input | 1 | Access is a write |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Read data, valid the cycle after a read |
| memEn | output | 1 | Shared memory enable |
| memWe | output | 1 | Shared memory write enable |
| memAddr | output | 17 | Physical byte address |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data, one cycle after memEn |
| inPortSel | output | 1 | Input port unit select |
| sndPortSel | output | 1 | Sound port unit select |
| blitSel | output | 1 | Blitter register file select |
| palSel | output | 1 | Palette store select |
| vidSel | output | 1 | Video line readback select |
| periphWe | output | 1 | Peripheral write strobe |
| periphAddr | output | 4 | Register offset for peripherals |
| periphWrData | output | 8 | Peripheral write data |
| inPortRdData | input | 8 | Input port read data |
| sndPortRdData | input | 8 | Sound port read data |
| blitRdData | input | 8 | Blitter read data |
| palRdData | input | 8 | Palette read data |
| videoLine | input | 8 | Upper bits of the video line counter |

## Verification
Memory address, enables and every select are combinational and are due in the same cycle as the access. The bench checks them one time unit after it drives the inputs, while the access is still presented. Read data comes one cycle after the access, because both the memory model and the source register are clocked. The bench samples it at the falling edge after that rising edge, and it changes videoLine at that same moment to show that the value was captured in the access cycle. A latch write only takes effect at its clock edge, so each bank test writes in one cycle and reads in a later one.

// File: rtl/bank_decode_pkg.sv
package bank_decode_pkg;
  localparam int unsigned CPU_AW  = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned PHYS_AW = CPU_AW + 1;
  localparam int unsigned REG_AW  = 4;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_MEM, SRC_INPORT, SRC_SNDPORT, SRC_BLIT, SRC_PAL, SRC_VIDEO
  } rdSrc_e;

  typedef struct packed {
    logic   memEn;
    logic   memWe;
    logic   romPage;
    logic   bankLoad;
    logic   rdTake;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;
endpackage

// File: rtl/bank_decode_ctrl.sv
module bank_decode_ctrl
  import bank_decode_pkg::*;
#(
  parameter logic [CPU_AW-1:0] BANK_END   = 16'h9000,
  parameter logic [CPU_AW-1:0] IO_BASE    = 16'hC000,
  parameter logic [CPU_AW-1:0] CFG_BASE   = 16'hCC00,
  parameter logic [CPU_AW-1:0] ROM_BASE   = 16'hD000,
  parameter logic [CPU_AW-1:0] PAL_BASE   = 16'hC000,
  parameter int unsigned       PAL_AW     = 4,
  parameter logic [CPU_AW-1:0] INP_BASE   = 16'hC804,
  parameter logic [CPU_AW-1:0] SND_BASE   = 16'hC80C,
  parameter int unsigned       PORT_AW    = 2,
  parameter logic [CPU_AW-1:0] BLIT_BASE  = 16'hCA00,
  parameter int unsigned       BLIT_AW    = 3,
  parameter logic [CPU_AW-1:0] BANK_REG   = 16'hC900,
  parameter logic [CPU_AW-1:0] VID_REG    = 16'hCB00
) (
  input  logic              cpuValid,
  input  logic              cpuWe,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic              bankRom,
  output ctrlStrobe_t       strobe,
  output logic              inPortSel,
  output logic              sndPortSel,
  output logic              blitSel,
  output logic              palSel,
  output logic              vidSel
);
  logic hitPal, hitInp, hitSnd, hitBlit, hitVid, hitBank;

  assign hitPal  = (cpuAddr >> PAL_AW)  == (PAL_BASE >> PAL_AW);
  assign hitInp  = (cpuAddr >> PORT_AW) == (INP_BASE >> PORT_AW);
  assign hitSnd  = (cpuAddr >> PORT_AW) == (SND_BASE >> PORT_AW);
  assign hitBlit = (cpuAddr >> BLIT_AW) == (BLIT_BASE >> BLIT_AW);
  assign hitVid  = cpuAddr == VID_REG;
  assign hitBank = cpuAddr == BANK_REG;

  always_comb begin
    strobe       = '0;
    strobe.rdSrc = SRC_NONE;
    inPortSel    = 1'b0;
    sndPortSel   = 1'b0;
    blitSel      = 1'b0;
    palSel       = 1'b0;
    vidSel       = 1'b0;
    if (cpuValid) begin
      strobe.rdTake = ~cpuWe;
      if (cpuAddr < BANK_END) begin
        strobe.memEn   = 1'b1;
        strobe.memWe   = cpuWe;
        strobe.romPage = ~cpuWe & bankRom;
        strobe.rdSrc   = SRC_MEM;
      end else if (cpuAddr < IO_BASE) begin
        strobe.memEn = 1'b1;
        strobe.memWe = cpuWe;
        strobe.rdSrc = SRC_MEM;
      end else if (cpuAddr >= ROM_BASE) begin
        if (!cpuWe) begin
          strobe.memEn   = 1'b1;
          strobe.romPage = 1'b1;
          strobe.rdSrc   = SRC_MEM;
        end
      end else if (cpuAddr >= CFG_BASE) begin
        strobe.memEn = 1'b1;
        strobe.memWe = cpuWe;
        strobe.rdSrc = SRC_MEM;
      end else if (hitPal) begin
        palSel       = 1'b1;
        strobe.rdSrc = SRC_PAL;
      end else if (hitInp) begin
        inPortSel    = 1'b1;
        strobe.rdSrc = SRC_INPORT;
      end else if (hitSnd) begin
        sndPortSel   = 1'b1;
        strobe.rdSrc = SRC_SNDPORT;
      end else if (hitBlit) begin
        blitSel      = 1'b1;
        strobe.rdSrc = SRC_BLIT;
      end else if (hitVid) begin
        vidSel       = 1'b1;
        strobe.rdSrc = SRC_VIDEO;
      end else if (hitBank) begin
        strobe.bankLoad = cpuWe;
      end
    end
  end
endmodule

// File: rtl/bank_decode_dp.sv
module bank_decode_dp
  import bank_decode_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic               bankBit,
  output logic               bankRom,
  output logic [PHYS_AW-1:0] memAddr,
  input  logic [DATA_W-1:0]  memRdData,
  input  logic [DATA_W-1:0]  inPortRdData,
  input  logic [DATA_W-1:0]  sndPortRdData,
  input  logic [DATA_W-1:0]  blitRdData,
  input  logic [DATA_W-1:0]  palRdData,
  input  logic [DATA_W-1:0]  videoLine,
  output logic [DATA_W-1:0]  cpuRdData
);
  rdSrc_e            srcQ;
  logic [DATA_W-1:0] vidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankRom <= 1'b0;
      srcQ    <= SRC_NONE;
      vidQ    <= '0;
    end else begin
      if (strobe.bankLoad) bankRom <= bankBit;
      if (strobe.rdTake) begin
        srcQ <= strobe.rdSrc;
        vidQ <= videoLine;
      end
    end
  end

  assign memAddr = {strobe.romPage, cpuAddr};

  always_comb begin
    unique case (srcQ)
      SRC_MEM:     cpuRdData = memRdData;
      SRC_INPORT:  cpuRdData = inPortRdData;
      SRC_SNDPORT: cpuRdData = sndPortRdData;
      SRC_BLIT:    cpuRdData = blitRdData;
      SRC_PAL:     cpuRdData = palRdData;
      SRC_VIDEO:   cpuRdData = vidQ;
      default:     cpuRdData = '1;
    endcase
  end
endmodule

// File: rtl/bank_addr_decode.sv
module bank_addr_decode
  import bank_decode_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuValid,
  input  logic               cpuWe,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWrData,
  output logic [DATA_W-1:0]  cpuRdData,
  output logic               memEn,
  output logic               memWe,
  output logic [PHYS_AW-1:0] memAddr,
  output logic [DATA_W-1:0]  memWrData,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               inPortSel,
  output logic               sndPortSel,
  output logic               blitSel,
  output logic               palSel,
  output logic               vidSel,
  output logic               periphWe,
  output logic [REG_AW-1:0]  periphAddr,
  output logic [DATA_W-1:0]  periphWrData,
  input  logic [DATA_W-1:0]  inPortRdData,
  input  logic [DATA_W-1:0]  sndPortRdData,
  input  logic [DATA_W-1:0]  blitRdData,
  input  logic [DATA_W-1:0]  palRdData,
  input  logic [DATA_W-1:0]  videoLine
);
  ctrlStrobe_t strobe;
  logic        bankRom;

  bank_decode_ctrl uCtrl (
    .cpuValid(cpuValid), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .bankRom(bankRom),
    .strobe(strobe), .inPortSel(inPortSel), .sndPortSel(sndPortSel),
    .blitSel(blitSel), .palSel(palSel), .vidSel(vidSel)
  );

  bank_decode_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr),
    .bankBit(cpuWrData[0]), .bankRom(bankRom), .memAddr(memAddr),
    .memRdData(memRdData), .inPortRdData(inPortRdData),
    .sndPortRdData(sndPortRdData), .blitRdData(blitRdData),
    .palRdData(palRdData), .videoLine(videoLine), .cpuRdData(cpuRdData)
  );

  assign memEn        = strobe.memEn;
  assign memWe        = strobe.memWe;
  assign memWrData    = cpuWrData;
  assign periphWe     = cpuValid & cpuWe;
  assign periphAddr   = cpuAddr[REG_AW-1:0];
  assign periphWrData = cpuWrData;
endmodule

// File: rtl/bank_addr_decode_chk.sv
module bank_addr_decode_chk
  import bank_decode_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cpuValid,
  input logic               cpuWe,
  input logic [CPU_AW-1:0]  cpuAddr,
  input logic [DATA_W-1:0]  cpuWrData,
  input logic [DATA_W-1:0]  cpuRdData,
  input logic               memEn,
  input logic               memWe,
  input logic [PHYS_AW-1:0] memAddr,
  input logic               inPortSel,
  input logic               sndPortSel,
  input logic               blitSel,
  input logic               palSel,
  input logic               vidSel,
  input logic [DATA_W-1:0]  videoLine
);
  // R8: selects never overlap
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inPortSel, sndPortSel, blitSel, palSel, vidSel}));

  // R4: banked writes land in RAM
  a_r4_bank_write_ram: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuWe && cpuAddr < 16'h9000) |-> (memWe && !memAddr[PHYS_AW-1]));

  // R6: fixed ROM is never written
  a_r6_rom_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuWe && cpuAddr >= 16'hD000) |-> (!memWe && !memEn));

  // R3: latch set to ROM steers the following banked read
  a_r3_latch_rom: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuValid && cpuWe && cpuAddr == 16'hC900 && cpuWrData[0])
     && cpuValid && !cpuWe && cpuAddr < 16'h9000) |-> memAddr[PHYS_AW-1]);

  // R10: video readback returns the line captured in the access cycle
  a_r10_video_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(cpuValid && !cpuWe && cpuAddr == 16'hCB00) |-> cpuRdData == $past(videoLine));

  // R12: I/O space below configuration RAM never touches memory
  a_r12_io_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuAddr >= 16'hC000 && cpuAddr < 16'hCC00) |-> !memEn);
endmodule

bind bank_addr_decode bank_addr_decode_chk uChk (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWe(cpuWe),
  .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
  .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
  .inPortSel(inPortSel), .sndPortSel(sndPortSel), .blitSel(blitSel),
  .palSel(palSel), .vidSel(vidSel), .videoLine(videoLine)
);

// File: tb/tb_bank_addr_decode.sv
module tb_bank_addr_decode;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic        memEn, memWe;
  logic [16:0] memAddr;
  logic [7:0]  memWrData, memRdData = '0;
  logic        inPortSel, sndPortSel, blitSel, palSel, vidSel, periphWe;
  logic [3:0]  periphAddr;
  logic [7:0]  periphWrData;
  logic [7:0]  inPortRdData = 8'hA1, sndPortRdData = 8'hB2;
  logic [7:0]  blitRdData = 8'hC3, palRdData = 8'hD4, videoLine = '0;
  int          nChecks = 0, nFails = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  bank_addr_decode dut (.*);

  function automatic logic [7:0] patt(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ (a[16] ? 8'h5A : 8'h00);
  endfunction

  always @(posedge clk) if (memEn) memRdData <= patt(memAddr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    cpuValid = 1'b1; cpuWe = we; cpuAddr = a; cpuWrData = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cpuValid = 1'b0; cpuWe = 1'b0;
    #1;
  endtask

  function automatic logic [4:0] sels();
    return {inPortSel, sndPortSel, blitSel, palSel, vidSel};
  endfunction

  task automatic memRead(input string req, input logic [15:0] a, input logic [16:0] phys);
    drive(a, 1'b0, 8'h00);
    chk(req, {memEn, memWe, memAddr}, {2'b10, phys});
    idle();
    chk({req, " data"}, cpuRdData, patt(phys));
  endtask

  task automatic setBank(input logic [7:0] d);
    drive(16'hC900, 1'b1, d);
    chk("R12 latch write no mem", {memEn, memWe}, 2'b00);
    idle();
  endtask

  task automatic tReset();
    chk("R1 reset rdData", cpuRdData, 8'hFF);
    memRead("R1 reset latch RAM", 16'h1234, 17'h01234);
  endtask

  task automatic tBankRead();
    memRead("R2 banked RAM read", 16'h0100, 17'h00100);
    memRead("R2 banked RAM top", 16'h8FFF, 17'h08FFF);
  endtask

  task automatic tBankSwitch();
    setBank(8'h01);
    memRead("R3 banked ROM read", 16'h1234, 17'h11234);
    memRead("R3 banked ROM top", 16'h8FFF, 17'h18FFF);
    setBank(8'hFE);
    memRead("R3 back to RAM", 16'h1234, 17'h01234);
  endtask

  task automatic tBankWrite();
    setBank(8'h01);
    drive(16'h2000, 1'b1, 8'h55);
    chk("R4 banked write to RAM", {memEn, memWe, memAddr}, {2'b11, 17'h02000});
    chk("R4 write data", memWrData, 8'h55);
    idle();
    memRead("R4 read still ROM", 16'h2000, 17'h12000);
  endtask

  task automatic tFixedRam();
    memRead("R5 fixed RAM low", 16'h9000, 17'h09000);
    memRead("R5 fixed RAM high", 16'hBFFF, 17'h0BFFF);
    drive(16'hA000, 1'b1, 8'h11);
    chk("R5 fixed RAM write", {memEn, memWe, memAddr}, {2'b11, 17'h0A000});
    idle();
    setBank(8'h00);
  endtask

  task automatic tRom();
    memRead("R6 ROM low", 16'hD000, 17'h1D000);
    memRead("R6 ROM high", 16'hFFFF, 17'h1FFFF);
    drive(16'hE000, 1'b1, 8'h22);
    chk("R6 ROM write ignored", {memEn, memWe}, 2'b00);
    idle();
  endtask

  task automatic tCfg();
    memRead("R7 config read", 16'hCC00, 17'h0CC00);
    drive(16'hCFFF, 1'b1, 8'h33);
    chk("R7 config write", {memEn, memWe, memAddr}, {2'b11, 17'h0CFFF});
    idle();
  endtask

  task automatic tPorts();
    drive(16'hC804, 1'b0, 8'h00);
    chk("R8 input select", sels(), 5'b10000);
    chk("R8 no mem on port", memEn, 1'b0);
    idle();
    chk("R8 idle no select", sels(), 5'b00000);
    chk("R11 input data", cpuRdData, 8'hA1);
    drive(16'hC807, 1'b1, 8'h44);
    chk("R8 input top + write", {sels(), periphWe, periphAddr, periphWrData},
        {5'b10000, 1'b1, 4'h7, 8'h44});
    idle();
    drive(16'hC80C, 1'b0, 8'h00);
    chk("R8 sound select", {sels(), periphAddr}, {5'b01000, 4'hC});
    idle();
    chk("R11 sound data", cpuRdData, 8'hB2);
    drive(16'hC80F, 1'b0, 8'h00);
    chk("R8 sound top", sels(), 5'b01000);
    idle();
    drive(16'hC808, 1'b0, 8'h00);
    chk("R12 gap select", sels(), 5'b00000);
    idle();
    chk("R12 gap data", cpuRdData, 8'hFF);
  endtask

  task automatic tBlitPal();
    drive(16'hCA00, 1'b0, 8'h00);
    chk("R9 blit low", sels(), 5'b00100);
    idle();
    chk("R11 blit data", cpuRdData, 8'hC3);
    drive(16'hCA07, 1'b0, 8'h00);
    chk("R9 blit high", sels(), 5'b00100);
    idle();
    drive(16'hCA08, 1'b0, 8'h00);
    chk("R9 blit past end", sels(), 5'b00000);
    idle();
    drive(16'hC00F, 1'b0, 8'h00);
    chk("R9 palette high", sels(), 5'b00010);
    idle();
    chk("R11 palette data", cpuRdData, 8'hD4);
    drive(16'hC005, 1'b1, 8'h9C);
    chk("R9 palette write", {sels(), periphWe}, {5'b00010, 1'b1});
    idle();
    drive(16'hC010, 1'b0, 8'h00);
    chk("R9 palette past end", sels(), 5'b00000);
    idle();
  endtask

  task automatic tVideo();
    videoLine = 8'h3C;
    drive(16'hCB00, 1'b0, 8'h00);
    chk("R10 video select", sels(), 5'b00001);
    @(negedge clk);
    cpuValid = 1'b0; videoLine = 8'h99;
    #1;
    chk("R10 video captured", cpuRdData, 8'h3C);
    idle();
    chk("R11 hold until next read", cpuRdData, 8'h3C);
  endtask

  task automatic tUnmapped();
    drive(16'hC100, 1'b0, 8'h00);
    chk("R12 unmapped no access", {sels(), memEn}, 6'b0);
    idle();
    chk("R12 unmapped data", cpuRdData, 8'hFF);
    memRead("R11 mem after io", 16'h0042, 17'h00042);
    drive(16'hC900, 1'b0, 8'h00);
    chk("R12 latch read no access", {sels(), memEn}, 6'b0);
    idle();
    chk("R12 latch read data", cpuRdData, 8'hFF);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset rdData pre", cpuRdData, 8'hFF);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    tReset();
    tBankRead();
    tBankSwitch();
    tBankWrite();
    tFixedRam();
    tRom();
    tCfg();
    tPorts();
    tBlitPal();
    tVideo();
    tUnmapped();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule